// File: doc/BRIEF.md
# Multi-scheme bus arbiter

This block decides which of `N_MASTERS` masters (four by default) owns a shared bus. It offers three arbitration schemes behind one interface, and a scheme select input chooses among them at run time. In the serial chain scheme, one shared request line asks for the bus. A grant token then travels from master 0 toward higher indices, and the first requesting master it reaches keeps it. In the polling scheme, a controller places a master address on `poll_addr` and steps through the masters. It stops on the first one that is requesting while addressed. In the fixed-priority scheme, each master has its own request and grant pair, and a priority decoder picks the lowest requesting index.

Arbitration runs only while the bus is idle, and its result is registered. A master keeps its grant for as long as its request stays high. When it drops the request, the grant is withdrawn at the next edge. The bus then spends one idle cycle before the next arbitration. The scheme select is latched only in idle cycles, so a change requested during a transfer waits until the bus is free.

Top module: `bus_arbiter_multi`

## Requirements
- R1: `grant` is zero or one-hot in every cycle. Reset gives `grant` = 0, `bus_busy` = 0, `poll_addr` = 0 and `scheme_act` = 0.
- R2: Scheme codes on `scheme_sel` are as follows: 0 is the serial chain, 1 is polling, and 2 and 3 are fixed priority. In every idle cycle (`bus_busy` = 0), `scheme_act` takes the value of `scheme_sel` at the next edge. While `bus_busy` = 1, `scheme_sel` is ignored and `scheme_act` holds.
- R3: In fixed priority, an idle cycle with any request makes the next edge set `bus_busy` and set `grant` to the one-hot bit of the lowest requesting index.
- R4: In the serial chain scheme, an idle cycle with any request grants, at the next edge, the first requesting master counted from index 0.
- R5: In polling, an idle cycle in which `req[poll_addr]` is high grants that master at the next edge. Otherwise, `poll_addr` advances by one at the next edge and wraps from `N_MASTERS`-1 to 0. This happens even when no master requests.
- R6: `poll_addr` does not change while `bus_busy` = 1.
- R7: While the owner keeps its request high, `grant` and `bus_busy` hold, whatever the other requests and `scheme_sel` do.
- R8: When the owner's request is low in a busy cycle, the next edge clears `grant` and `bus_busy`. The next grant comes at the earliest one edge later.
- R9: When a grant won under polling is released, `poll_addr` becomes the owner's index plus one, modulo `N_MASTERS`. Releasing a grant won under another scheme leaves `poll_addr` unchanged.
- R10: While idle under a non-polling scheme, `poll_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MASTERS | Request line of each master |
| scheme_sel | input | 2 | Requested arbitration scheme |
| grant | output | N_MASTERS | Registered one-hot grant |
| poll_addr | output | $clog2(N_MASTERS) | Master address driven by the polling controller |
| bus_busy | output | 1 | High while a master owns the bus |
| scheme_act | output | 2 | Scheme latched for the current or last arbitration |

## Verification
The hardest state to reach from the ports is a release in polling mode that lands on a wrapped address. The poll address must already sit on a high index while that master requests. The same master must then drop its request while the bus is busy, and the scheme select must meanwhile try to change. Random requests flip only a quarter of their bits each cycle, so owners hold for several cycles and scheme changes during transfers happen often. Directed sequences park the poll address on the top index, grant it, change the scheme mid-transfer and release the grant, which checks the wrap and the held scheme together.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    SCH_CHAIN   = 2'd0,
    SCH_POLL    = 2'd1,
    SCH_FIXED   = 2'd2,
    SCH_FIXED_B = 2'd3
  } scheme_e;

  localparam int MAX_MASTERS = 64;

  // next address in a ring of n positions
  function automatic int ring_next(int idx, int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction

  // index of the single set bit (lowest one if several)
  function automatic int onehot_index(logic [MAX_MASTERS-1:0] vec);
    int idx;
    idx = 0;
    for (int i = MAX_MASTERS - 1; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/arb_chain.sv
module arb_chain #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  output logic [N_MASTERS-1:0] pick
);

  logic                 shared_req;
  logic [N_MASTERS:0]   token;

  assign shared_req = |req;
  assign token[0]   = shared_req;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_link
    // a requesting master absorbs the token, others pass it on
    assign pick[i]      = token[i] & req[i];
    assign token[i + 1] = token[i] & ~req[i];
  end

  // R4: the token stops on the first requester counted from index 0
  assert_chain_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ((pick != '0) && ((pick & req) == pick) &&
                (((pick - N_MASTERS'(1)) & req) == '0)));

  assert_chain_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (pick == '0));

endmodule

// File: rtl/arb_fixed.sv
module arb_fixed #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  output logic [N_MASTERS-1:0] pick
);

  function automatic logic [N_MASTERS-1:0] decode(logic [N_MASTERS-1:0] r);
    logic [N_MASTERS-1:0] o;
    o = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (r[i]) o = N_MASTERS'(1) << i;
    end
    return o;
  endfunction

  assign pick = decode(req);

  // R3: only the lowest requesting index is chosen
  assert_fixed_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($onehot(pick) && ((pick & req) == pick) &&
                (((pick - N_MASTERS'(1)) & req) == '0)));

endmodule

// File: rtl/arb_poller.sv
module arb_poller
  import bus_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  localparam int AW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 scan_en,
  input  logic                 rel_poll,
  input  logic [AW-1:0]        rel_owner,
  output logic [AW-1:0]        addr_q,
  output logic [N_MASTERS-1:0] pick
);

  logic addr_hit;
  logic step_en;

  assign addr_hit = req[addr_q];
  assign step_en  = scan_en & ~addr_hit;

  always_comb begin
    pick = '0;
    if (scan_en && addr_hit) pick[addr_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (rel_poll) begin
      addr_q <= AW'(ring_next(int'(rel_owner), N_MASTERS));
    end else if (step_en) begin
      addr_q <= AW'(ring_next(int'(addr_q), N_MASTERS));
    end
  end

  // R5: a miss moves the address one place on, with wrap
  assert_poll_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !rel_poll) |=> (addr_q == AW'(ring_next(int'($past(addr_q)), N_MASTERS))));

  // R6: address frozen when neither scanning nor resuming
  assert_poll_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !rel_poll) |=> $stable(addr_q));

  // R9: resume after the last owner
  assert_poll_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_poll |=> (addr_q == AW'(ring_next(int'($past(rel_owner)), N_MASTERS))));

  assert_poll_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick) && ((pick & req) == pick));

endmodule

// File: rtl/bus_arbiter_multi.sv
module bus_arbiter_multi
  import bus_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  localparam int AW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic [1:0]           scheme_sel,
  output logic [N_MASTERS-1:0] grant,
  output logic [AW-1:0]        poll_addr,
  output logic                 bus_busy,
  output logic [1:0]           scheme_act
);

  logic [N_MASTERS-1:0] pick_chain;
  logic [N_MASTERS-1:0] pick_fixed;
  logic [N_MASTERS-1:0] pick_poll;
  logic [N_MASTERS-1:0] winner;
  logic [AW-1:0]        owner_q;
  logic                 scan_en;
  logic                 arb_fire;
  logic                 release_now;
  logic                 rel_poll;

  arb_chain #(.N_MASTERS(N_MASTERS)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .pick (pick_chain)
  );

  arb_fixed #(.N_MASTERS(N_MASTERS)) u_fixed (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .pick (pick_fixed)
  );

  assign scan_en     = ~bus_busy & (scheme_e'(scheme_sel) == SCH_POLL);
  assign release_now = bus_busy & ~req[owner_q];
  assign rel_poll    = release_now & (scheme_e'(scheme_act) == SCH_POLL);

  arb_poller #(.N_MASTERS(N_MASTERS)) u_poller (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .scan_en  (scan_en),
    .rel_poll (rel_poll),
    .rel_owner(owner_q),
    .addr_q   (poll_addr),
    .pick     (pick_poll)
  );

  always_comb begin
    case (scheme_e'(scheme_sel))
      SCH_CHAIN: winner = pick_chain;
      SCH_POLL:  winner = pick_poll;
      default:   winner = pick_fixed;
    endcase
  end

  assign arb_fire = ~bus_busy & (|winner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy   <= 1'b0;
      owner_q    <= '0;
      grant      <= '0;
      scheme_act <= SCH_CHAIN;
    end else begin
      if (!bus_busy) scheme_act <= scheme_sel;
      if (release_now) begin
        bus_busy <= 1'b0;
        grant    <= '0;
      end else if (arb_fire) begin
        bus_busy <= 1'b1;
        grant    <= winner;
        owner_q  <= AW'(onehot_index(MAX_MASTERS'(winner)));
      end
    end
  end

  // R1: never more than one grant
  assert_grant_onehot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (bus_busy == (grant != '0)));

  // R2: scheme held while a transfer is in progress
  assert_scheme_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> $stable(scheme_act));

  // R3: an idle cycle with a request in a non-polling scheme gives a grant
  assert_idle_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && (req != '0) && (scheme_sel != 2'd1)) |=> bus_busy);

  // R7: owner still requesting keeps the bus
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && ((req & grant) != '0)) |=> (bus_busy && $stable(grant)));

  // R8: owner dropping its request frees the bus for one cycle
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && ((req & grant) == '0)) |=> (!bus_busy && (grant == '0)));

endmodule

// File: tb/bus_arbiter_multi_tb.sv
module bus_arbiter_multi_tb;

  localparam int N  = 4;
  localparam int AW = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [1:0]    scheme_sel;
  logic [N-1:0]  grant;
  logic [AW-1:0] poll_addr;
  logic          bus_busy;
  logic [1:0]    scheme_act;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model state
  bit          m_busy;
  int          m_owner;
  logic [N-1:0] m_grant;
  logic [1:0]  m_scheme;
  int          m_paddr;
  string       m_tag;

  bus_arbiter_multi #(.N_MASTERS(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .scheme_sel(scheme_sel),
    .grant     (grant),
    .poll_addr (poll_addr),
    .bus_busy  (bus_busy),
    .scheme_act(scheme_act)
  );

  initial clk = 0;
  always #10 clk = ~clk; // 50 MHz

  function automatic int lowest_set(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model of one clock edge given the inputs presented for it
  task automatic model_edge(logic [N-1:0] r, logic [1:0] s);
    if (m_busy) begin
      if (!r[m_owner]) begin
        m_busy = 0; m_grant = '0;
        if (m_scheme == 2'd1) begin m_paddr = (m_owner + 1) % N; m_tag = "R9"; end
        else m_tag = "R8";
      end else m_tag = "R7";
    end else begin
      m_scheme = s;
      if (s == 2'd1) begin
        if (r[m_paddr]) begin
          m_busy = 1; m_owner = m_paddr; m_grant = N'(1) << m_paddr;
        end else m_paddr = (m_paddr + 1) % N;
        m_tag = "R5";
      end else begin
        if (r != '0) begin
          m_owner = lowest_set(r); m_busy = 1; m_grant = N'(1) << m_owner;
        end
        m_tag = (s == 2'd0) ? "R4" : "R3";
      end
    end
  endtask

  task automatic compare();
    check({m_tag, " grant"}, int'(grant), int'(m_grant));
    check({m_tag, " busy"}, int'(bus_busy), int'(m_busy));
    check(m_busy ? "R6 poll_addr" : (m_scheme == 2'd1 ? "R5 poll_addr" : "R10 poll_addr"),
          int'(poll_addr), m_paddr);
    check("R2 scheme_act", int'(scheme_act), int'(m_scheme));
    check("R1 onehot0", int'($onehot0(grant)), 1);
  endtask

  task automatic step(logic [N-1:0] r, logic [1:0] s);
    @(negedge clk);
    compare();
    req = r; scheme_sel = s;
    model_edge(r, s);
  endtask

  initial begin
    logic [N-1:0] cur;
    logic [1:0]   sc;
    void'($urandom(32'h5eed1234));
    rst_n = 0; req = '0; scheme_sel = 2'd0;
    m_busy = 0; m_owner = 0; m_grant = '0; m_scheme = 2'd0; m_paddr = 0; m_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset grant", int'(grant), 0);
    check("R1 reset busy", int'(bus_busy), 0);
    check("R1 reset poll_addr", int'(poll_addr), 0);
    check("R1 reset scheme", int'(scheme_act), 0);
    rst_n = 1;

    // R4: chain, master 0 silent, token stops at 1
    step(4'b1110, 2'd0);
    step(4'b1110, 2'd0);
    step(4'b1010, 2'd1);  // R2: scheme change while busy ignored
    step(4'b1000, 2'd1);  // R8: release
    step(4'b1000, 2'd2);  // R3: fixed picks 3
    step(4'b1000, 2'd2);
    step(4'b0000, 2'd1);  // release
    // R5: polling walks and wraps with no requests
    for (int i = 0; i < 6; i++) step(4'b0000, 2'd1);
    // park address on top index and grant it
    for (int i = 0; i < N; i++) begin
      if (m_paddr == N - 1) break;
      step(4'b0000, 2'd1);
    end
    step(4'b1001, 2'd1);  // hit on index 3
    step(4'b1001, 2'd0);  // R6, R2: busy, scheme request ignored
    step(4'b0001, 2'd2);  // R9: release, resume wraps to 0
    step(4'b0001, 2'd1);  // idle: poll hits 0
    step(4'b0000, 2'd1);
    step(4'b0000, 2'd2);
    step(4'b0100, 2'd2);  // R10: fixed idle, poll_addr held
    step(4'b0000, 2'd2);

    // constrained random traffic
    cur = '0; sc = 2'd0;
    for (int i = 0; i < 4000; i++) begin
      cur = cur ^ (N'($urandom) & N'($urandom));
      if (($urandom % 8) == 0) sc = 2'($urandom);
      step(cur, sc);
    end
    step('0, sc);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule